// File: doc/BRIEF.md
# Compressed Super-Block Entry Manager

This block manages a set-associative tag store in which every tag names a super-block of four neighbouring blocks. Each tag owns exactly one data way. A per-entry flag records whether that way holds one uncompressed block or up to four compressed blocks of the same super-block. For every read or writeback, an external compressor supplies two plain inputs: a "compressible" bit and a one-bit encoding-scheme identifier. The block then decides whether the requested block joins an existing compressed way, gets a way of its own, or is only remembered as touched once ("first-use") and bypassed.

Each slot of an entry is invalid, valid or first-use. A block that is touched for the first time in a super-block that is already resident, and that cannot be packed, is only marked first-use. It earns a data way when it is touched again. Writebacks update only valid, compatible copies. Every other writeback is sent to memory, and a writeback whose new contents no longer fit the compressed way also drops the resident copy. The block reports the chosen way, that way's slot states after the update, its compressed flag, the action taken and whether a live way was displaced. The data array, the memory and the compression itself sit outside the block.

Top module: `sbc_top`

## Requirements
- R1: After reset no response is reported, all entries are empty, and the first read of any set allocates way 0.
- R2: A read whose super-block matches no live entry allocates the lowest way with zero valid slots. The new entry holds only the requested slot as valid, and its compressed flag equals the request's compressible bit. The action code is ALLOC (2).
- R3: A read whose slot is valid in a matching entry reports HIT (0) with that way and changes no state.
- R4: A read that matches a tag but has no valid copy, and that is compressible, packs into the lowest-numbered matching entry that meets three conditions: the entry is compressed, its scheme equals the request's scheme, and it holds fewer than four valid slots. The slot becomes valid and the action code is PACK (1).
- R5: If that read cannot be packed and its slot is first-use in no matching entry, the slot becomes first-use in every matching entry. No way is allocated. The action code is FIRSTUSE (3), and the response names the lowest matching way.
- R6: A read that cannot be packed and finds its slot first-use in a matching entry allocates a new way for the block, following the rules of R2 and R11.
- R7: At most one entry holds a given block as valid. Whenever a read packs or allocates a block, that slot becomes invalid in every other matching entry.
- R8: A writeback to a valid slot reports WB_UPDATE (4) and changes no state in two cases: the entry is uncompressed, or the data is compressible with the entry's scheme.
- R9: A writeback to a valid slot of a compressed entry, with data that is incompressible or uses the other scheme, reports WB_EVICT (5) and invalidates that slot.
- R10: A writeback whose slot is first-use, invalid or absent reports WB_MEM (6) and changes no state. The response names the lowest matching way, or way 0 if none matches.
- R11: An entry with zero valid slots counts as free, even if it has first-use slots. When no way of the set is free, the victim is taken from a per-set round-robin pointer that starts at 0 and advances on each such eviction. rsp_evict is 1 exactly in that case.
- R12: Every accepted request produces one response in the next cycle, and no response appears otherwise. rsp_slots gives the chosen way's state after the update, with slot s in bits [2s+1:2s] (invalid 0, valid 1, first-use 2). rsp_comp gives that way's compressed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_wb | input | 1 | 1 = writeback, 0 = read |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Super-block tag |
| req_slot | input | 2 | Block position inside the super-block |
| req_cmp | input | 1 | Block is compressible (from compressor) |
| req_scheme | input | 1 | Encoding scheme chosen by compressor |
| rsp_valid | output | 1 | Response present |
| rsp_action | output | 3 | Action code (see requirements) |
| rsp_way | output | WAY_W | Way the action applied to |
| rsp_slots | output | 8 | Slot states of that way after the update |
| rsp_comp | output | 1 | Compressed flag of that way |
| rsp_evict | output | 1 | A way with valid slots was displaced |

## Verification
The assertions assume three things about every cycle with req_valid high: the request fields carry known values, req_set names an existing set, and req_scheme matters only when req_cmp is set. The stimulus holds the fields steady between falling edges and draws set indices only from the configured range. It draws tags from a pool of four values, so super-blocks alias heavily and every set is driven into full-way eviction. The compressibility and scheme bits change freely from one request to the next, which covers the packing refusals and the incompatible writebacks.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  typedef logic [1:0] slot_st_t;
  localparam slot_st_t ST_INV = 2'd0;
  localparam slot_st_t ST_VAL = 2'd1;
  localparam slot_st_t ST_FU  = 2'd2;

  typedef logic [SLOTS-1:0][1:0] slot_vec_t;
  typedef logic [CNT_W-1:0]      cnt_t;

  typedef struct packed {
    logic      comp;
    logic      scheme;
    slot_vec_t slots;
  } meta_t;

  typedef enum logic [2:0] {
    ACT_HIT      = 3'd0,
    ACT_PACK     = 3'd1,
    ACT_ALLOC    = 3'd2,
    ACT_FIRST    = 3'd3,
    ACT_WB_UPD   = 3'd4,
    ACT_WB_EVICT = 3'd5,
    ACT_WB_MEM   = 3'd6
  } act_t;

  // number of slots holding a valid block
  function automatic cnt_t val_count(input slot_vec_t s);
    cnt_t n;
    n = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (s[k] == ST_VAL) n = n + cnt_t'(1);
    end
    return n;
  endfunction

  // an entry keeps its tag while any slot is not invalid
  function automatic logic entry_live(input slot_vec_t s);
    return |s;
  endfunction

  // new data may stay in the way that holds it
  function automatic logic wb_fits(input logic comp, input logic scheme,
                                   input logic cmp, input logic sch);
    return !comp || (cmp && (scheme == sch));
  endfunction
endpackage

// File: rtl/sbc_match.sv
module sbc_match
  import sbc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  meta_t [WAYS-1:0]           set_meta,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [SLOT_W-1:0]          req_slot,
  input  logic                       req_cmp,
  input  logic                       req_scheme,
  output logic [WAYS-1:0]            hit_mask,
  output logic [WAYS-1:0]            val_mask,
  output logic [WAYS-1:0]            fu_mask,
  output logic [WAYS-1:0]            pack_mask,
  output logic [WAYS-1:0]            free_mask,
  output logic [WAYS-1:0]            wbok_mask
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    slot_st_t st;
    cnt_t     nval;
    logic     live;
    logic     room;

    assign st   = set_meta[w].slots[req_slot];
    assign nval = val_count(set_meta[w].slots);
    assign live = entry_live(set_meta[w].slots);
    assign room = (nval < cnt_t'(SLOTS));

    assign hit_mask[w]  = live && (set_tags[w] == req_tag);
    assign val_mask[w]  = hit_mask[w] && (st == ST_VAL);
    assign fu_mask[w]   = hit_mask[w] && (st == ST_FU);
    assign pack_mask[w] = hit_mask[w] && (st != ST_VAL) && set_meta[w].comp &&
                          req_cmp && (set_meta[w].scheme == req_scheme) && room;
    assign free_mask[w] = (nval == '0);
    assign wbok_mask[w] = wb_fits(set_meta[w].comp, set_meta[w].scheme,
                                  req_cmp, req_scheme);
  end
endmodule

// File: rtl/sbc_decide.sv
module sbc_decide
  import sbc_pkg::*;
#(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             req_wb,
  input  logic [WAYS-1:0]  hit_mask,
  input  logic [WAYS-1:0]  val_mask,
  input  logic [WAYS-1:0]  fu_mask,
  input  logic [WAYS-1:0]  pack_mask,
  input  logic [WAYS-1:0]  free_mask,
  input  logic [WAYS-1:0]  wbok_mask,
  input  logic [WAY_W-1:0] rr_ptr,
  output act_t             act,
  output logic [WAY_W-1:0] tgt_way,
  output logic             evict,
  output logic             rr_adv
);
  logic [WAY_W-1:0] first_hit, first_val, first_pack, first_free, victim;
  logic             any_free;

  always_comb begin
    first_hit  = '0;
    first_val  = '0;
    first_pack = '0;
    first_free = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_mask[w])  first_hit  = WAY_W'(w);
      if (val_mask[w])  first_val  = WAY_W'(w);
      if (pack_mask[w]) first_pack = WAY_W'(w);
      if (free_mask[w]) first_free = WAY_W'(w);
    end
    any_free = |free_mask;
    victim   = any_free ? first_free : rr_ptr;
  end

  always_comb begin
    act     = ACT_HIT;
    tgt_way = '0;
    evict   = 1'b0;
    if (req_wb) begin
      if (|val_mask) begin
        act     = wbok_mask[first_val] ? ACT_WB_UPD : ACT_WB_EVICT;
        tgt_way = first_val;
      end else begin
        act     = ACT_WB_MEM;
        tgt_way = (|hit_mask) ? first_hit : '0;
      end
    end else if (|val_mask) begin
      act     = ACT_HIT;
      tgt_way = first_val;
    end else if (|pack_mask) begin
      act     = ACT_PACK;
      tgt_way = first_pack;
    end else if ((|fu_mask) || !(|hit_mask)) begin
      act     = ACT_ALLOC;
      tgt_way = victim;
      evict   = !any_free;
    end else begin
      act     = ACT_FIRST;
      tgt_way = first_hit;
    end
    rr_adv = (act == ACT_ALLOC) && !any_free;
  end
endmodule

// File: rtl/sbc_store.sv
module sbc_store
  import sbc_pkg::*;
#(
  parameter int SETS  = 2,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [SET_W-1:0]           req_set,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [SLOT_W-1:0]          req_slot,
  input  logic                       req_cmp,
  input  logic                       req_scheme,
  input  act_t                       act,
  input  logic [WAY_W-1:0]           tgt_way,
  input  logic [WAYS-1:0]            hit_mask,
  input  logic                       rr_adv,
  output logic [WAYS-1:0][TAG_W-1:0] set_tags,
  output meta_t [WAYS-1:0]           set_meta,
  output logic [WAY_W-1:0]           rr_ptr,
  output meta_t                      tgt_next
);
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  meta_t            meta_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q   [SETS];

  logic [WAYS-1:0][TAG_W-1:0] nxt_tags;
  meta_t [WAYS-1:0]           nxt_meta;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w] = tag_q[req_set][w];
      set_meta[w] = meta_q[req_set][w];
    end
    rr_ptr = rr_q[req_set];
  end

  always_comb begin
    nxt_tags = set_tags;
    nxt_meta = set_meta;
    case (act)
      ACT_PACK: begin
        for (int w = 0; w < WAYS; w++)
          if (hit_mask[w]) nxt_meta[w].slots[req_slot] = ST_INV;
        nxt_meta[tgt_way].slots[req_slot] = ST_VAL;
      end
      ACT_ALLOC: begin
        for (int w = 0; w < WAYS; w++)
          if (hit_mask[w]) nxt_meta[w].slots[req_slot] = ST_INV;
        nxt_tags[tgt_way]        = req_tag;
        nxt_meta[tgt_way].comp   = req_cmp;
        nxt_meta[tgt_way].scheme = req_scheme;
        nxt_meta[tgt_way].slots  = '0;
        nxt_meta[tgt_way].slots[req_slot] = ST_VAL;
      end
      ACT_FIRST: begin
        for (int w = 0; w < WAYS; w++)
          if (hit_mask[w]) nxt_meta[w].slots[req_slot] = ST_FU;
      end
      ACT_WB_EVICT: nxt_meta[tgt_way].slots[req_slot] = ST_INV;
      default: ;
    endcase
    tgt_next = nxt_meta[tgt_way];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          meta_q[s][w] <= '0;
        end
      end
    end else if (req_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        tag_q[req_set][w]  <= nxt_tags[w];
        meta_q[req_set][w] <= nxt_meta[w];
      end
      if (rr_adv)
        rr_q[req_set] <= (rr_q[req_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[req_set] + WAY_W'(1);
    end
  end
endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter int SETS  = 2,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_wb,
  input  logic [SET_W-1:0]   req_set,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [SLOT_W-1:0]  req_slot,
  input  logic               req_cmp,
  input  logic               req_scheme,
  output logic               rsp_valid,
  output logic [2:0]         rsp_action,
  output logic [WAY_W-1:0]   rsp_way,
  output logic [2*SLOTS-1:0] rsp_slots,
  output logic               rsp_comp,
  output logic               rsp_evict
);
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  meta_t [WAYS-1:0]           set_meta;
  logic [WAY_W-1:0]           rr_ptr;
  meta_t                      tgt_next;
  logic [WAYS-1:0] hit_mask, val_mask, fu_mask, pack_mask, free_mask, wbok_mask;
  act_t             act;
  logic [WAY_W-1:0] tgt_way;
  logic             evict, rr_adv;

  // named events for the checker
  logic ev_alloc, ev_pack, ev_first, ev_wb_evict;
  assign ev_alloc    = req_valid && (act == ACT_ALLOC);
  assign ev_pack     = req_valid && (act == ACT_PACK);
  assign ev_first    = req_valid && (act == ACT_FIRST);
  assign ev_wb_evict = req_valid && (act == ACT_WB_EVICT);

  sbc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
    .req_tag(req_tag), .req_slot(req_slot), .req_cmp(req_cmp),
    .req_scheme(req_scheme), .act(act), .tgt_way(tgt_way),
    .hit_mask(hit_mask), .rr_adv(rr_adv), .set_tags(set_tags),
    .set_meta(set_meta), .rr_ptr(rr_ptr), .tgt_next(tgt_next)
  );

  sbc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .set_tags(set_tags), .set_meta(set_meta), .req_tag(req_tag),
    .req_slot(req_slot), .req_cmp(req_cmp), .req_scheme(req_scheme),
    .hit_mask(hit_mask), .val_mask(val_mask), .fu_mask(fu_mask),
    .pack_mask(pack_mask), .free_mask(free_mask), .wbok_mask(wbok_mask)
  );

  sbc_decide #(.WAYS(WAYS)) decide_i (
    .req_wb(req_wb), .hit_mask(hit_mask), .val_mask(val_mask),
    .fu_mask(fu_mask), .pack_mask(pack_mask), .free_mask(free_mask),
    .wbok_mask(wbok_mask), .rr_ptr(rr_ptr), .act(act), .tgt_way(tgt_way),
    .evict(evict), .rr_adv(rr_adv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_action <= '0;
      rsp_way    <= '0;
      rsp_slots  <= '0;
      rsp_comp   <= 1'b0;
      rsp_evict  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_action <= act;
        rsp_way    <= tgt_way;
        rsp_slots  <= tgt_next.slots;
        rsp_comp   <= tgt_next.comp;
        rsp_evict  <= evict;
      end
    end
  end
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk
  import sbc_pkg::*;
#(
  parameter int WAYS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_wb,
  input logic [SLOT_W-1:0]  req_slot,
  input logic               req_cmp,
  input logic [WAYS-1:0]    val_mask,
  input logic               ev_alloc,
  input logic               ev_pack,
  input logic               ev_first,
  input logic               ev_wb_evict,
  input logic               rsp_valid,
  input logic [2:0]         rsp_action,
  input logic [2*SLOTS-1:0] rsp_slots,
  input logic               rsp_comp,
  input logic               rsp_evict
);
  logic [SLOT_W-1:0] slot_q;
  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= req_slot;
  end

  slot_st_t st_at;
  assign st_at = rsp_slots[2*slot_q +: 2];

  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R12
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(val_mask) <= 1); // R7
  AST_ALLOC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> rsp_comp == $past(req_cmp) && st_at == ST_VAL); // R2
  AST_PACK_COMPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pack |=> rsp_comp && st_at == ST_VAL); // R4
  AST_FIRST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> st_at == ST_FU); // R5
  AST_WB_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_evict |=> st_at == ST_INV && rsp_comp); // R9
  AST_WB_NEVER_ALLOCS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wb |=> rsp_action >= 3'd4); // R10
  AST_READ_NO_WB_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_wb |=> rsp_action < 3'd4); // R3
  AST_EVICT_ONLY_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_evict |-> rsp_action == 3'd2); // R11
endmodule

bind sbc_top sbc_chk #(.WAYS(WAYS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wb(req_wb),
  .req_slot(req_slot), .req_cmp(req_cmp), .val_mask(val_mask),
  .ev_alloc(ev_alloc), .ev_pack(ev_pack), .ev_first(ev_first),
  .ev_wb_evict(ev_wb_evict), .rsp_valid(rsp_valid), .rsp_action(rsp_action),
  .rsp_slots(rsp_slots), .rsp_comp(rsp_comp), .rsp_evict(rsp_evict)
);

// File: tb/sbc_top_tb_top.sv
module sbc_top_tb_top;
  localparam int SETS = 2;
  localparam int WAYS = 4;
  localparam int TAG_W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_wb = 1'b0, req_cmp = 1'b0, req_scheme = 1'b0;
  logic [0:0] req_set = '0;
  logic [7:0] req_tag = '0;
  logic [1:0] req_slot = '0;
  logic       rsp_valid, rsp_comp, rsp_evict;
  logic [2:0] rsp_action;
  logic [1:0] rsp_way;
  logic [7:0] rsp_slots;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sbc_top #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wb(req_wb),
    .req_set(req_set), .req_tag(req_tag), .req_slot(req_slot),
    .req_cmp(req_cmp), .req_scheme(req_scheme), .rsp_valid(rsp_valid),
    .rsp_action(rsp_action), .rsp_way(rsp_way), .rsp_slots(rsp_slots),
    .rsp_comp(rsp_comp), .rsp_evict(rsp_evict)
  );

  // reference state: st 0 invalid, 1 valid, 2 first-use
  int  m_tag [SETS][WAYS];
  bit  m_cmp [SETS][WAYS];
  bit  m_sch [SETS][WAYS];
  int  m_st  [SETS][WAYS][4];
  int  m_rr  [SETS];
  bit  fresh;

  int    e_act, e_way;
  bit    e_comp, e_evict;
  int    e_slots;
  string e_req;

  task automatic model(input bit wb, input int s, input int tag, input int k,
                       input bit cmp, input bit sch);
    int hits[$], vals[$], fus[$], packs[$], frees[$];
    for (int w = 0; w < WAYS; w++) begin
      int nv = 0;
      bit live = 0;
      for (int j = 0; j < 4; j++) begin
        if (m_st[s][w][j] == 1) nv++;
        if (m_st[s][w][j] != 0) live = 1;
      end
      if (nv == 0) frees.push_back(w);
      if (live && m_tag[s][w] == tag) begin
        hits.push_back(w);
        if (m_st[s][w][k] == 1) vals.push_back(w);
        if (m_st[s][w][k] == 2) fus.push_back(w);
        if (m_st[s][w][k] != 1 && m_cmp[s][w] && cmp && m_sch[s][w] == sch && nv < 4)
          packs.push_back(w);
      end
    end
    e_evict = 0;
    if (wb) begin
      if (vals.size() > 0) begin
        e_way = vals[0];
        if (!m_cmp[s][e_way] || (cmp && m_sch[s][e_way] == sch)) begin
          e_act = 4; e_req = "R8";
        end else begin
          e_act = 5; e_req = "R9"; m_st[s][e_way][k] = 0;
        end
      end else begin
        e_act = 6; e_req = "R10";
        e_way = (hits.size() > 0) ? hits[0] : 0;
      end
    end else if (vals.size() > 0) begin
      e_act = 0; e_way = vals[0]; e_req = "R3";
    end else if (packs.size() > 0) begin
      e_act = 1; e_way = packs[0];
      e_req = (fus.size() > 0) ? "R7" : "R4";
      foreach (hits[i]) m_st[s][hits[i]][k] = 0;
      m_st[s][e_way][k] = 1;
    end else if (fus.size() > 0 || hits.size() == 0) begin
      e_act = 2;
      e_req = (fus.size() > 0) ? "R6" : "R2";
      foreach (hits[i]) m_st[s][hits[i]][k] = 0;
      if (frees.size() > 0) e_way = frees[0];
      else begin
        e_way = m_rr[s]; e_evict = 1; e_req = "R11";
        m_rr[s] = (m_rr[s] + 1) % WAYS;
      end
      if (fresh) e_req = "R1";
      m_tag[s][e_way] = tag; m_cmp[s][e_way] = cmp; m_sch[s][e_way] = sch;
      for (int j = 0; j < 4; j++) m_st[s][e_way][j] = 0;
      m_st[s][e_way][k] = 1;
    end else begin
      e_act = 3; e_way = hits[0]; e_req = "R5";
      foreach (hits[i]) m_st[s][hits[i]][k] = 2;
    end
    fresh = 0;
    e_comp = m_cmp[s][e_way];
    e_slots = 0;
    for (int j = 0; j < 4; j++) e_slots |= (m_st[s][e_way][j] << (2 * j));
  endtask

  task automatic step(input bit v, input bit wb, input int s, input int tag,
                      input int k, input bit cmp, input bit sch);
    @(negedge clk);
    req_valid = v; req_wb = wb; req_set = 1'(s); req_tag = 8'(tag);
    req_slot = 2'(k); req_cmp = cmp; req_scheme = sch;
    if (v) model(wb, s, tag, k, cmp, sch);
    @(posedge clk);
    #1;
    n_cmp++;
    if (!v) begin
      if (rsp_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R12: rsp_valid=%0b expected 0 on idle cycle", rsp_valid);
      end
    end else if (rsp_valid !== 1'b1 || rsp_action !== 3'(e_act) || rsp_way !== 2'(e_way) ||
                 rsp_slots !== 8'(e_slots) || rsp_comp !== e_comp || rsp_evict !== e_evict) begin
      n_bad++;
      $display("FAIL %s (R12): v=%0b act=%0d way=%0d slots=%h comp=%0b ev=%0b expected v=1 act=%0d way=%0d slots=%h comp=%0b ev=%0b",
               e_req, rsp_valid, rsp_action, rsp_way, rsp_slots, rsp_comp, rsp_evict,
               e_act, e_way, e_slots[7:0], e_comp, e_evict);
    end
  endtask

  initial begin
    #(4ns * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_tag[s][w] = 0; m_cmp[s][w] = 0; m_sch[s][w] = 0;
        for (int j = 0; j < 4; j++) m_st[s][w][j] = 0;
      end
    end
    fresh = 1;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rsp_valid=%0b in reset, expected 0", rsp_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // directed walk through every case in set 0
    step(1, 0, 0, 5, 2, 0, 0);   // R1 first allocation, way 0
    step(1, 0, 0, 5, 2, 0, 0);   // R3 hit
    step(1, 0, 0, 5, 0, 0, 0);   // R5 first-use
    step(1, 0, 0, 5, 0, 0, 0);   // R6 reuse allocates way 1, R7 clears way 0
    step(1, 0, 0, 5, 3, 0, 0);   // R5 marks both entries
    step(1, 1, 0, 5, 3, 0, 0);   // R10 writeback of first-use slot
    step(0, 0, 0, 0, 0, 0, 0);   // R12 idle
    step(1, 0, 0, 9, 1, 1, 0);   // R2 compressed allocation
    step(1, 0, 0, 9, 3, 1, 0);   // R4 pack
    step(1, 0, 0, 9, 0, 1, 1);   // R5 scheme mismatch
    step(1, 0, 0, 9, 0, 1, 0);   // R7 reuse packs, first-use cleared
    step(1, 0, 0, 9, 2, 1, 0);   // R4 fills fourth slot
    step(1, 0, 0, 9, 1, 1, 0);   // R3
    step(1, 1, 0, 9, 3, 1, 0);   // R8 compatible writeback
    step(1, 1, 0, 9, 3, 0, 0);   // R9 incompatible writeback
    step(1, 1, 0, 9, 3, 1, 0);   // R10 slot now invalid
    step(1, 0, 0, 12, 0, 0, 0);  // R2 way 3
    step(1, 0, 0, 13, 0, 0, 0);  // R11 round-robin victim way 0
    step(1, 0, 0, 14, 1, 0, 0);  // R11 next victim
    // random traffic with heavy aliasing
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom_range(0, 9) != 0);
      step(v, bit'($urandom_range(0, 3) == 0), $urandom_range(0, SETS - 1),
           $urandom_range(0, 3), $urandom_range(0, 3),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule